// File: doc/BRIEF.md
# Paired-Sample History Detector

This block is a small clocked state machine with two single-bit inputs, `a` and `b`, and one registered output, `z`. On every rising clock edge it samples both inputs. The output goes high when the `a` sample just taken has the same value as the `a` sample taken on the edge before it. Once high, the output stays high for as long as `b` is sampled as 1 on every edge that follows. A single `b` sample of 0, with no new `a` match on that edge, drops the output. Only a fresh pair of equal `a` samples can raise it again.

Both inputs are assumed to be synchronous to `clk` already. The design is split into a control unit and a datapath. The control unit tracks how much valid `a` history exists. The datapath holds the previous `a` sample and the persistence flag that drives `z`. The control steers the datapath through a small struct of strobes.

Top module: `pair_history_fsm`

## Requirements
- R1: `rst` is synchronous and active high. After a clock edge with `rst` = 1, `z` is 0 and all `a` history is discarded.
- R2: `z` is registered. Samples taken on an edge can change `z` only after that edge, never before it.
- R3: If the `a` sample on edge k equals the `a` sample on edge k-1, and both were taken after the last reset, then `z` is 1 after edge k, whatever `b` is.
- R4: The first `a` sample after a reset, or after recovery from an unused state, can never produce a match.
- R5: If `z` is 1 and `b` is sampled as 1 on an edge, then `z` stays 1 after that edge, whatever `a` is.
- R6: If `z` is 1, `b` is sampled as 0, and there is no `a` match on that edge, then `z` becomes 0. After that, `b` = 1 alone does not bring it back.
- R7: In every case not covered by R3 and R5, `z` is 0 after the edge.
- R8: The 2-bit control state uses the codes 00 (no history), 01 (one sample held) and 10 (history valid). Code 11 is unused. From code 11 the machine goes to code 00 on the next edge, with `z` = 0, and ignores the `a` sample taken on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 1 | Input whose consecutive samples are compared |
| b | input | 1 | Input that keeps `z` high once it has been raised |
| z | output | 1 | Registered detector output |

## Verification
The bench looks at the edge right after reset. A design that compared against a stale or reset-value `a` history would raise `z` on the first sample there. It also checks the edge where `b` drops while `a` happens to match again. A design that gave the clear priority over the match would wrongly lower `z` on that edge. Long runs of `b` = 1 after a clear catch a design that lets `b` alone raise the output. Forcing the unused state code catches a design that does not recover, or that carries a stale sample or a stale flag out of that code.

// File: rtl/pair_history_pkg.sv
package pair_history_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_INIT = 2'b00,
    ST_ONE  = 2'b01,
    ST_RUN  = 2'b10
  } hist_state_t;

  typedef struct packed {
    logic loadA;
    logic setHold;
    logic clrHold;
  } hist_strobe_t;

endpackage

// File: rtl/pair_history_dp.sv
module pair_history_dp
  import pair_history_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         a,
  input  hist_strobe_t strobe,
  output logic         aEq,
  output logic         holdQ
);

  logic aLastQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      aLastQ <= 1'b0;
    end else if (strobe.loadA) begin
      aLastQ <= a;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdQ <= 1'b0;
    end else if (strobe.setHold) begin
      holdQ <= 1'b1;
    end else if (strobe.clrHold) begin
      holdQ <= 1'b0;
    end
  end

  assign aEq = (a == aLastQ);

  // R6: a clear strobe without a set always lowers the flag
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (strobe.clrHold && !strobe.setHold) |=> !holdQ);

endmodule

// File: rtl/pair_history_ctrl.sv
module pair_history_ctrl
  import pair_history_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         b,
  input  logic         aEq,
  input  logic         holdIn,
  output hist_strobe_t strobe
);

  hist_state_t stateQ;
  hist_state_t stateD;
  logic        histValid;
  logic        legal;

  assign histValid = (stateQ == ST_ONE) || (stateQ == ST_RUN);
  assign legal     = histValid || (stateQ == ST_INIT);

  always_comb begin
    strobe.loadA   = legal;
    strobe.setHold = histValid && aEq;
    strobe.clrHold = !(histValid && aEq) && (!histValid || !b);
  end

  always_comb begin
    case (stateQ)
      ST_INIT: stateD = ST_ONE;
      ST_ONE:  stateD = ST_RUN;
      ST_RUN:  stateD = ST_RUN;
      default: stateD = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_INIT;
    end else begin
      stateQ <= stateD;
    end
  end

  // R1: reset leaves no history and a low output
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (stateQ == ST_INIT) && !holdIn);

  // R3: an equal pair of samples raises the output
  a_r3_match_sets: assert property (@(posedge clk) disable iff (rst)
    (histValid && aEq) |=> holdIn);

  // R4: the first sample after reset or recovery never raises the output
  a_r4_no_early_match: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_INIT) |=> !holdIn);

  // R5: b held at 1 keeps a raised output high
  a_r5_hold_persists: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_RUN && holdIn && b) |=> holdIn);

  // R7: b alone cannot raise a low output
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (histValid && !aEq && !holdIn) |=> !holdIn);

  // R8: the unused code recovers to the initial state
  a_r8_unused_recovers: assert property (@(posedge clk) disable iff (rst)
    !legal |=> (stateQ == ST_INIT) && !holdIn);

endmodule

// File: rtl/pair_history_fsm.sv
module pair_history_fsm
  import pair_history_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  output logic z
);

  hist_strobe_t strobe;
  logic         aEq;
  logic         holdQ;

  pair_history_ctrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .b      (b),
    .aEq    (aEq),
    .holdIn (holdQ),
    .strobe (strobe)
  );

  pair_history_dp uDp (
    .clk    (clk),
    .rst    (rst),
    .a      (a),
    .strobe (strobe),
    .aEq    (aEq),
    .holdQ  (holdQ)
  );

  assign z = holdQ;

endmodule

// File: tb/pair_history_fsm_test.sv
`timescale 1ns/1ps
module pair_history_fsm_test;
  import pair_history_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a = 1'b0;
  logic b = 1'b0;
  logic z;

  int checks = 0;
  int errors = 0;

  // model state
  int   mCnt = 0;
  logic mLastA = 1'b0;
  logic mZ = 1'b0;

  localparam int NVEC = 22;
  // each entry is {a, b}
  localparam logic [1:0] STIM [0:NVEC-1] = '{
    2'b10, 2'b10, 2'b01, 2'b01, 2'b11, 2'b00, 2'b01, 2'b11,
    2'b00, 2'b10, 2'b01, 2'b11, 2'b01, 2'b11, 2'b10, 2'b00,
    2'b00, 2'b11, 2'b01, 2'b10, 2'b10, 2'b11
  };

  pair_history_fsm uut (
    .clk (clk),
    .rst (rst),
    .a   (a),
    .b   (b),
    .z   (z)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: z=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    mCnt = 0;
    mZ = 1'b0;
  endtask

  task automatic step(input logic ai, input logic bi, input string tagIn);
    logic  match;
    string tag;
    @(negedge clk);
    a = ai;
    b = bi;
    #1;
    check("R2", z, mZ);  // new inputs must not show before the edge
    match = (mCnt >= 1) && (ai == mLastA);
    if (tagIn != "") tag = tagIn;
    else if (match) tag = "R3";
    else if (mZ && bi) tag = "R5";
    else if (mZ && !bi) tag = "R6";
    else tag = "R7";
    mZ = match || (mZ && bi);
    mLastA = ai;
    if (mCnt < 2) mCnt++;
    @(posedge clk);
    #1;
    check(tag, z, mZ);
  endtask

  initial begin
    #1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    check("R1", z, 1'b0);

    // R4: first sample after reset cannot match; second equal one does
    step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b0, "R3");

    for (int i = 0; i < NVEC; i++) begin
      step(STIM[i][1], STIM[i][0], "");
    end

    // R6: clear, then b alone stays low
    step(1'b1, 1'b1, "R3");
    step(1'b0, 1'b0, "R6");
    step(1'b1, 1'b1, "R6");
    step(1'b0, 1'b1, "R6");

    // match wins over a dropping b
    step(1'b0, 1'b0, "R3");

    // R1: reset mid-run with z high, then R4 with a value equal to the old one
    step(1'b0, 1'b1, "R5");
    do_reset();
    check("R1", z, 1'b0);
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b1, "R3");

    // R8: force the unused code 11 while z is high
    step(1'b1, 1'b1, "R5");
    @(negedge clk);
    a = 1'b1;
    b = 1'b1;
    force uut.uCtrl.stateQ = hist_state_t'(2'b11);
    #1;
    release uut.uCtrl.stateQ;
    @(posedge clk);
    #1;
    mCnt = 0;
    mZ = 1'b0;
    check("R8", z, 1'b0);
    step(1'b1, 1'b1, "R8");
    step(1'b1, 1'b1, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule